// File: doc/BRIEF.md
# Block Copy DMA Master

This engine copies a block of 32-bit words from one memory region to another by taking its own turn on a shared AHB bus, so the processor is free while the copy runs. Software sets a source byte address, a destination byte address and a word count through a four-entry register port, then writes a start bit. The engine then works through the block in chunks of up to four words. For each chunk it raises its bus request and waits for the grant. It fetches the chunk into an internal buffer with one incrementing read burst, stores it at the destination with one write burst, and then drops the request for at least one cycle.

When the last chunk has been written, a level interrupt is raised. It stays high until software clears it. Wait states from the slave are honoured on both reads and writes.

Top module: `dma_copy_engine`

## Requirements
- R1: After a start with count N > 0, the N words at the source appear at the destination in order, and the word just past the destination block is left unchanged. The beat address of each direction starts at its base and advances by 4 for each accepted beat.
- R2: The bus request is high whenever a chunk is in progress. HTRANS is never non-IDLE while the request is low.
- R3: A beat is driven only while the grant input is high. A beat counts as issued at a clock edge where both the grant and HREADY are high.
- R4: Each burst begins with NONSEQ (2'b10) and every later beat is SEQ (2'b11) at the previous beat address plus 4. IDLE is 2'b00. HSIZE is always word (3'b010).
- R5: While a driven beat sees HREADY low, the engine holds HTRANS and HADDR stable. Read data is captured only on cycles where HREADY is high.
- R6: Each chunk holds at most 4 words. All reads of a chunk finish before its write burst starts. The request falls once per chunk, so a block of N words makes ceil(N/4) read bursts, ceil(N/4) write bursts and ceil(N/4) request releases.
- R7: HBURST is 3'b011 (4-beat incrementing) for a 4-word chunk, 3'b001 (undefined-length incrementing) for a 2- or 3-word chunk, and 3'b000 (single) for a 1-word chunk.
- R8: The interrupt output rises after the last write of the block and stays high until a register write to offset 3 with bit 1 set. If a completion and a clear happen in the same cycle, the completion wins.
- R9: A start write made while the engine is busy is ignored. The copy in flight keeps its original addresses and count, and no extra bursts are made.
- R10: A start with a count of zero sets the interrupt on the clock edge of the start write and never raises the bus request.
- R11: Register map, word offsets on a 2-bit register address:
  - Offset 0 holds the source address, offset 1 the destination address and offset 2 the word count. Each reads back what was written.
  - Offset 3 writes bit 0 = start and bit 1 = interrupt clear.
  - Offset 3 reads bit 0 = interrupt and bit 1 = busy.
  - All registers reset to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register word offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational from offset |
| irq_o | output | 1 | Completion interrupt, level |
| hbusreq_o | output | 1 | Bus request to the arbiter |
| hgrant_i | input | 1 | Bus grant from the arbiter |
| hready_i | input | 1 | Transfer ready from the slave |
| htrans_o | output | 2 | Transfer type |
| haddr_o | output | ADDR_W | Byte address |
| hwrite_o | output | 1 | High for write beats |
| hsize_o | output | 3 | Transfer size |
| hburst_o | output | 3 | Burst type |
| hwdata_o | output | 32 | Write data for the current data phase |
| hrdata_i | input | 32 | Read data from the slave |

## Verification
A register write takes effect on the clock edge that samples it. The start of a zero-length block is therefore visible on the interrupt output at the very next sampling point after the write, and the bench checks it there. Bus outputs are combinational from state and from the grant, so a beat is due in the same cycle that its grant and HREADY are presented. The bench drives HREADY and the grant just after the falling edge and samples the bus two nanoseconds later, ahead of the rising edge that accepts the beat. That sample is used for the burst, hold, address and request checks. Memory contents, burst counts and the interrupt are checked only once the interrupt is seen, and the wait for it has a time limit.

// File: rtl/dma_pkg.sv
package dma_pkg;
  typedef enum logic [1:0] {
    TR_IDLE   = 2'b00,
    TR_BUSY   = 2'b01,
    TR_NONSEQ = 2'b10,
    TR_SEQ    = 2'b11
  } htrans_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_READ,
    ST_WRITE,
    ST_GAP
  } seq_state_e;

  localparam logic [2:0] BURST_SINGLE = 3'b000;
  localparam logic [2:0] BURST_INCR   = 3'b001;
  localparam logic [2:0] BURST_INCR4  = 3'b011;
  localparam logic [2:0] BURST_INCR8  = 3'b101;
  localparam logic [2:0] BURST_INCR16 = 3'b111;
  localparam logic [2:0] SIZE_WORD    = 3'b010;
endpackage

// File: rtl/dma_regs.sv
module dma_regs #(
  parameter int AW = 32,
  parameter int LW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [1:0]    addr_i,
  input  logic [31:0]   wdata_i,
  output logic [31:0]   rdata_o,
  input  logic          busy_i,
  input  logic          done_i,
  output logic [AW-1:0] src_o,
  output logic [AW-1:0] dst_o,
  output logic [LW-1:0] len_o,
  output logic          start_o,
  output logic          irq_o
);
  localparam logic [1:0] OFS_SRC = 2'd0;
  localparam logic [1:0] OFS_DST = 2'd1;
  localparam logic [1:0] OFS_LEN = 2'd2;
  localparam logic [1:0] OFS_CTL = 2'd3;

  logic ctl_wr;
  assign ctl_wr  = we_i && (addr_i == OFS_CTL);
  assign start_o = ctl_wr && wdata_i[0] && !busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_o <= '0;
      dst_o <= '0;
      len_o <= '0;
      irq_o <= 1'b0;
    end else begin
      if (we_i && addr_i == OFS_SRC) src_o <= wdata_i[AW-1:0];
      if (we_i && addr_i == OFS_DST) dst_o <= wdata_i[AW-1:0];
      if (we_i && addr_i == OFS_LEN) len_o <= wdata_i[LW-1:0];
      // completion beats a simultaneous clear
      if (done_i)                      irq_o <= 1'b1;
      else if (ctl_wr && wdata_i[1])   irq_o <= 1'b0;
    end
  end

  always_comb begin
    unique case (addr_i)
      OFS_SRC: rdata_o = 32'(src_o);
      OFS_DST: rdata_o = 32'(dst_o);
      OFS_LEN: rdata_o = 32'(len_o);
      default: rdata_o = {30'b0, busy_i, irq_o};
    endcase
  end

  a_r8_irq_from_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(done_i));
endmodule

// File: rtl/dma_chunk_buf.sv
module dma_chunk_buf #(
  parameter  int DEPTH = 4,
  parameter  int DW    = 32,
  localparam int IW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [IW-1:0] widx_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [IW-1:0] ridx_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[widx_i] <= wdata_i;
  end

  assign rdata_o = mem_q[ridx_i];
endmodule

// File: rtl/dma_seq.sv
module dma_seq
  import dma_pkg::*;
#(
  parameter int AW    = 32,
  parameter int LW    = 16,
  parameter int CHUNK = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] src_i,
  input  logic [AW-1:0] dst_i,
  input  logic [LW-1:0] len_i,
  output logic          busy_o,
  output logic          done_o,
  input  logic          hgrant_i,
  input  logic          hready_i,
  input  logic [31:0]   hrdata_i,
  output logic          hbusreq_o,
  output logic [1:0]    htrans_o,
  output logic [AW-1:0] haddr_o,
  output logic          hwrite_o,
  output logic [2:0]    hburst_o,
  output logic [2:0]    hsize_o,
  output logic [31:0]   hwdata_o
);
  localparam int CW = $clog2(CHUNK + 1);
  localparam int IW = (CHUNK > 1) ? $clog2(CHUNK) : 1;
  localparam logic [2:0] FULL_BURST =
    (CHUNK == 4)  ? BURST_INCR4 :
    (CHUNK == 8)  ? BURST_INCR8 :
    (CHUNK == 16) ? BURST_INCR16 : BURST_INCR;

  seq_state_e    state_q;
  logic [AW-1:0] src_q, dst_q;
  logic [LW-1:0] rem_q;
  logic [CW-1:0] acnt_q, dcnt_q, nb;
  logic          dvalid_q, active, go_addr, last_data;
  logic [31:0]   buf_rdata;

  always_comb begin
    if (rem_q >= LW'(CHUNK)) nb = CW'(CHUNK);
    else                     nb = rem_q[CW-1:0];
  end

  assign active    = (state_q == ST_READ) || (state_q == ST_WRITE);
  assign go_addr   = active && (acnt_q < nb) && hgrant_i;
  assign last_data = dvalid_q && hready_i && (dcnt_q == nb - CW'(1));

  assign hbusreq_o = active;
  assign htrans_o  = !go_addr ? TR_IDLE : (acnt_q == '0 ? TR_NONSEQ : TR_SEQ);
  assign hwrite_o  = (state_q == ST_WRITE);
  assign haddr_o   = (hwrite_o ? dst_q : src_q) + (AW'(acnt_q) << 2);
  assign hsize_o   = SIZE_WORD;
  assign hburst_o  = (nb == CW'(1)) ? BURST_SINGLE :
                     (nb == CW'(CHUNK)) ? FULL_BURST : BURST_INCR;
  assign hwdata_o  = (hwrite_o && dvalid_q) ? buf_rdata : '0;
  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = (state_q == ST_IDLE && start_i && len_i == '0) ||
                     (state_q == ST_GAP && rem_q == '0);

  dma_chunk_buf #(.DEPTH(CHUNK), .DW(32)) u_buf (
    .clk_i  (clk_i),
    .we_i   ((state_q == ST_READ) && dvalid_q && hready_i),
    .widx_i (dcnt_q[IW-1:0]),
    .wdata_i(hrdata_i),
    .ridx_i (dcnt_q[IW-1:0]),
    .rdata_o(buf_rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      src_q    <= '0;
      dst_q    <= '0;
      rem_q    <= '0;
      acnt_q   <= '0;
      dcnt_q   <= '0;
      dvalid_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start_i && len_i != '0) begin
            src_q   <= src_i;
            dst_q   <= dst_i;
            rem_q   <= len_i;
            acnt_q  <= '0;
            dcnt_q  <= '0;
            state_q <= ST_READ;
          end
        end
        ST_READ, ST_WRITE: begin
          if (hready_i) begin
            if (last_data) begin
              acnt_q   <= '0;
              dcnt_q   <= '0;
              dvalid_q <= 1'b0;
              if (state_q == ST_READ) begin
                state_q <= ST_WRITE;
              end else begin
                src_q   <= src_q + (AW'(nb) << 2);
                dst_q   <= dst_q + (AW'(nb) << 2);
                rem_q   <= rem_q - LW'(nb);
                state_q <= ST_GAP;
              end
            end else begin
              if (go_addr)  acnt_q <= acnt_q + CW'(1);
              if (dvalid_q) dcnt_q <= dcnt_q + CW'(1);
              dvalid_q <= go_addr;
            end
          end
        end
        default: state_q <= (rem_q == '0) ? ST_IDLE : ST_READ;
      endcase
    end
  end

  a_r2_trans_needs_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (htrans_o != TR_IDLE) |-> hbusreq_o);
  a_r4_seq_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(go_addr && hready_i) && htrans_o == TR_SEQ) |-> (haddr_o == $past(haddr_o) + AW'(4)));
  a_r5_hold_on_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (htrans_o != TR_IDLE && !hready_i && hgrant_i) |=>
      (!hgrant_i || ($stable(haddr_o) && $stable(htrans_o))));
  a_r6_release_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hbusreq_o) |-> (htrans_o == TR_IDLE && !dvalid_q));
  a_r10_zero_no_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && len_i == '0) |=> !hbusreq_o);
endmodule

// File: rtl/dma_copy_engine.sv
module dma_copy_engine #(
  parameter int ADDR_W      = 32,
  parameter int LEN_W       = 16,
  parameter int CHUNK_WORDS = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              irq_o,
  output logic              hbusreq_o,
  input  logic              hgrant_i,
  input  logic              hready_i,
  output logic [1:0]        htrans_o,
  output logic [ADDR_W-1:0] haddr_o,
  output logic              hwrite_o,
  output logic [2:0]        hsize_o,
  output logic [2:0]        hburst_o,
  output logic [31:0]       hwdata_o,
  input  logic [31:0]       hrdata_i
);
  logic [ADDR_W-1:0] src, dst;
  logic [LEN_W-1:0]  len;
  logic              start, busy, done;

  dma_regs #(.AW(ADDR_W), .LW(LEN_W)) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (reg_we_i),
    .addr_i (reg_addr_i),
    .wdata_i(reg_wdata_i),
    .rdata_o(reg_rdata_o),
    .busy_i (busy),
    .done_i (done),
    .src_o  (src),
    .dst_o  (dst),
    .len_o  (len),
    .start_o(start),
    .irq_o  (irq_o)
  );

  dma_seq #(.AW(ADDR_W), .LW(LEN_W), .CHUNK(CHUNK_WORDS)) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start),
    .src_i    (src),
    .dst_i    (dst),
    .len_i    (len),
    .busy_o   (busy),
    .done_o   (done),
    .hgrant_i (hgrant_i),
    .hready_i (hready_i),
    .hrdata_i (hrdata_i),
    .hbusreq_o(hbusreq_o),
    .htrans_o (htrans_o),
    .haddr_o  (haddr_o),
    .hwrite_o (hwrite_o),
    .hburst_o (hburst_o),
    .hsize_o  (hsize_o),
    .hwdata_o (hwdata_o)
  );
endmodule

// File: tb/tb_dma_copy_engine.sv
`timescale 1ns/1ps
module tb_dma_copy_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic        irq, hbusreq, hwrite;
  logic        hgrant = 1'b0;
  logic        hready = 1'b1;
  logic [1:0]  htrans;
  logic [31:0] haddr, hwdata, hrdata;
  logic [2:0]  hsize, hburst;

  always #4 clk = ~clk;

  dma_copy_engine dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .irq_o(irq),
    .hbusreq_o(hbusreq), .hgrant_i(hgrant), .hready_i(hready), .htrans_o(htrans),
    .haddr_o(haddr), .hwrite_o(hwrite), .hsize_o(hsize), .hburst_o(hburst),
    .hwdata_o(hwdata), .hrdata_i(hrdata)
  );

  // memory slave
  logic [31:0] mem [256];
  logic        dp_v = 1'b0, dp_w = 1'b0;
  logic [7:0]  dp_a = 8'd0;
  assign hrdata = dp_v ? mem[dp_a] : 32'd0;
  always @(posedge clk) begin
    if (!rst_n) dp_v <= 1'b0;
    else if (hready) begin
      if (dp_v && dp_w) mem[dp_a] <= hwdata;
      dp_v <= htrans[1];
      dp_a <= haddr[9:2];
      dp_w <= hwrite;
    end
  end

  function automatic logic [31:0] pat(int k);
    return 32'hC0DE_0000 ^ (32'(k) * 32'h0001_0203);
  endfunction

  // stimulus table: src word, dst word, count, wait states, grant delay
  localparam int NV = 6;
  localparam int V_SRC [NV] = '{0, 8, 16, 20, 40, 0};
  localparam int V_DST [NV] = '{64, 100, 128, 140, 180, 200};
  localparam int V_LEN [NV] = '{4, 7, 1, 10, 3, 13};
  localparam int V_WT  [NV] = '{0, 1, 0, 1, 1, 1};
  localparam int V_GD  [NV] = '{0, 3, 2, 0, 5, 1};

  int n_chk = 0, n_fail = 0;
  int wait_en = 0, gdelay = 0, req_cnt = 0;
  logic [7:0] lfsr = 8'hA5;
  int v_r1, v_r2, v_r3, v_r4, v_r5, v_r6, v_r7;
  int nonseq_rd, nonseq_wr, req_drops, req_seen;
  int rd_rem, wr_rem, rem, n, exp_b;
  logic [31:0] exp_ra, exp_wa, last_acc, prev_addr;
  logic [1:0]  prev_trans;
  logic        prev_pend, prev_req;

  task automatic clear_mon(int src, int dst, int len);
    v_r1 = 0; v_r2 = 0; v_r3 = 0; v_r4 = 0; v_r5 = 0; v_r6 = 0; v_r7 = 0;
    nonseq_rd = 0; nonseq_wr = 0; req_drops = 0; req_seen = 0;
    rd_rem = len; wr_rem = len;
    exp_ra = 32'(src * 4); exp_wa = 32'(dst * 4);
  endtask

  // arbiter, wait-state driver and bus monitor
  initial begin
    prev_pend = 0; prev_req = 0; prev_addr = 0; prev_trans = 0; last_acc = 0;
    clear_mon(0, 0, 0);
    forever begin
      @(negedge clk);
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      hready = (wait_en != 0) ? (lfsr[0] | lfsr[1]) : 1'b1;
      if (hbusreq) req_cnt++; else req_cnt = 0;
      hgrant = hbusreq && (req_cnt > gdelay);
      #2;
      if (htrans[1] && !hgrant) v_r3++;
      if (htrans != 2'b00 && !hbusreq) v_r2++;
      if (prev_pend && hgrant && (htrans != prev_trans || haddr != prev_addr)) v_r5++;
      if (htrans[1] && hready && hgrant) begin
        if (hsize != 3'b010) v_r4++;
        if (htrans == 2'b10) begin
          rem = hwrite ? wr_rem : rd_rem;
          n = (rem > 4) ? 4 : rem;
          exp_b = (n == 4) ? 3 : ((n == 1) ? 0 : 1);
          if (32'(hburst) != 32'(exp_b)) v_r7++;
          if (hwrite) begin
            nonseq_wr++;
            if (wr_rem - rd_rem != n) v_r6++;
          end else nonseq_rd++;
        end else if (haddr != last_acc + 32'd4) v_r4++;
        if (haddr != (hwrite ? exp_wa : exp_ra)) v_r1++;
        if (hwrite) begin exp_wa += 4; wr_rem--; end
        else begin exp_ra += 4; rd_rem--; end
        last_acc = haddr;
      end
      if (hbusreq) req_seen++;
      if (prev_req && !hbusreq) req_drops++;
      prev_pend = htrans[1] && !hready;
      prev_trans = htrans; prev_addr = haddr; prev_req = hbusreq;
    end
  end

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic reg_wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_rd(logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_irq(output bit ok);
    ok = 0;
    for (int c = 0; c < 3000; c++) begin
      @(negedge clk);
      if (irq) begin ok = 1; break; end
    end
  endtask

  task automatic init_mem();
    for (int k = 0; k < 256; k++) mem[k] = pat(k);
  endtask

  task automatic run_copy(int src, int dst, int len);
    clear_mon(src, dst, len);
    reg_wr(2'd0, 32'(src * 4));
    reg_wr(2'd1, 32'(dst * 4));
    reg_wr(2'd2, 32'(len));
    reg_wr(2'd3, 32'd1);
  endtask

  task automatic check_copy(int src, int dst, int len, string tag);
    int bad = 0;
    int nch = (len + 3) / 4;
    for (int k = 0; k < len; k++) if (mem[dst + k] != pat(src + k)) bad++;
    check(bad == 0, {tag, " R1 data"}, 32'(bad), 0);
    check(mem[dst + len] == pat(dst + len), {tag, " R1 past end"}, mem[dst + len], pat(dst + len));
    check(v_r1 == 0, {tag, " R1 beat address"}, 32'(v_r1), 0);
    check(v_r2 == 0, {tag, " R2 trans without req"}, 32'(v_r2), 0);
    check(v_r3 == 0, {tag, " R3 trans without grant"}, 32'(v_r3), 0);
    check(v_r4 == 0, {tag, " R4 seq/size"}, 32'(v_r4), 0);
    check(v_r5 == 0, {tag, " R5 wait hold"}, 32'(v_r5), 0);
    check(v_r6 == 0, {tag, " R6 read before write"}, 32'(v_r6), 0);
    check(v_r7 == 0, {tag, " R7 burst code"}, 32'(v_r7), 0);
    check(nonseq_rd == nch, {tag, " R6 read bursts"}, 32'(nonseq_rd), 32'(nch));
    check(nonseq_wr == nch, {tag, " R6 write bursts"}, 32'(nonseq_wr), 32'(nch));
    check(req_drops == nch, {tag, " R6 request releases"}, 32'(req_drops), 32'(nch));
  endtask

  initial begin
    logic [31:0] rd;
    bit ok;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    check(irq == 1'b0, "R8 reset irq", 32'(irq), 0);
    check(hbusreq == 1'b0, "R2 reset request", 32'(hbusreq), 0);
    check(htrans == 2'b00, "R4 reset idle", 32'(htrans), 0);
    reg_rd(2'd3, rd);
    check(rd == 32'd0, "R11 reset status", rd, 0);
    reg_rd(2'd0, rd);
    check(rd == 32'd0, "R11 reset source", rd, 0);
    reg_wr(2'd1, 32'h1234_5678);
    reg_rd(2'd1, rd);
    check(rd == 32'h1234_5678, "R11 destination readback", rd, 32'h1234_5678);

    // table walk
    for (int i = 0; i < NV; i++) begin
      init_mem();
      wait_en = V_WT[i]; gdelay = V_GD[i];
      run_copy(V_SRC[i], V_DST[i], V_LEN[i]);
      wait_irq(ok);
      check(ok, $sformatf("vec%0d R8 irq raised", i), 32'(ok), 1);
      check_copy(V_SRC[i], V_DST[i], V_LEN[i], $sformatf("vec%0d", i));
      repeat (5) @(negedge clk);
      check(irq == 1'b1, $sformatf("vec%0d R8 irq held", i), 32'(irq), 1);
      reg_wr(2'd3, 32'd2);
      check(irq == 1'b0, $sformatf("vec%0d R8 irq cleared", i), 32'(irq), 0);
    end

    // zero count
    wait_en = 0; gdelay = 0;
    clear_mon(0, 0, 0);
    reg_wr(2'd2, 32'd0);
    reg_wr(2'd3, 32'd1);
    check(irq == 1'b1, "R10 zero count irq", 32'(irq), 1);
    repeat (4) @(negedge clk);
    check(req_seen == 0, "R10 zero count no request", 32'(req_seen), 0);
    reg_wr(2'd3, 32'd2);

    // start while busy
    init_mem();
    wait_en = 1; gdelay = 4;
    run_copy(0, 64, 8);
    reg_rd(2'd3, rd);
    check(rd[1] == 1'b1, "R11 busy status", rd, 32'h2);
    reg_wr(2'd0, 32'(160 * 4));
    reg_wr(2'd3, 32'd1);
    wait_irq(ok);
    check(ok, "R9 irq after busy start", 32'(ok), 1);
    begin
      int bad = 0;
      for (int k = 0; k < 8; k++) if (mem[64 + k] != pat(k)) bad++;
      check(bad == 0, "R9 original source kept", 32'(bad), 0);
    end
    repeat (10) @(negedge clk);
    check(nonseq_rd == 2, "R9 no extra bursts", 32'(nonseq_rd), 2);
    check(hbusreq == 1'b0, "R9 engine idle", 32'(hbusreq), 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog timeout actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule